// File: doc/BRIEF.md
# Display Column Driver Bus Command Controller

This block is the processor-facing front end of a dot-matrix display column driver. It listens to an 8-bit parallel bus with an active-low chip enable, a write-select line and a data/instruction select line. Instruction bytes are decoded into mode registers: display enable, counter choice, count direction and memory region. Address and start-line loads are passed out as one-cycle strobes to address counters that live elsewhere. A status byte can be read back at any time.

Display data reads and writes go to an external memory port. Reads pass through a one-deep output register: each read returns what the register held and then refills it from the addressed byte. The first read after an address load is therefore a dummy read. Every accepted bus transaction other than a status read starts a busy window. The window closes on the second rising edge of a slow internal clock. Transactions that arrive while it is open are dropped.

All bus inputs are sampled on the system clock `clk_i`, and a bus transaction completes on the low-to-high transition of `ce_ni`.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: A write (`wr_ni`=0) is captured in the system-clock cycle where `ce_ni` is seen going from 0 to 1. `db_oe_o` is 1 exactly while `ce_ni`=0 and `wr_ni`=1.
- R2: Instruction byte `0000001d` sets the display enable to d. It produces no memory write strobe.
- R3: Instruction byte `000001yu` selects the counter (y=1 for the page counter, y=0 for the column counter) and the direction (u=1 up, u=0 down).
- R4: Instruction `01aaaaaa` pulses `zload_o` with start line a. `10aaaaaa` pulses `xload_o` with column address a. `11xfaaaa` pulses `pload_o` with page a and sets the flag-memory mode to f. Each strobe lasts one cycle, in the cycle after the completing edge.
- R5: With `wr_ni`=1, `di_i`=0 and `ce_ni`=0, `db_o` carries the status byte. From bit 7 down it is: busy, 0, display on, reset held, 0, flag mode, counter select, direction.
- R6: Any accepted transaction other than a status read sets busy. Busy clears on the second rising edge of `phi_i` seen after the transaction completes.
- R7: Instructions, data writes and data reads that complete while busy is 1 are discarded. They change no mode, strobe nothing and do not restart busy.
- R8: A data read (`wr_ni`=1, `di_i`=1) drives the output register onto `db_o`. On completion it loads `mem_rdata_i` into that register and pulses `mem_rd_o` and `step_o` together. The first read after an address load returns the stale value.
- R9: A data write pulses `mem_wr_o` and `step_o` for one cycle, with `mem_wdata_o` equal to the captured byte.
- R10: While `rst_ni`=0 the display is off, counter select and direction are 1, flag mode is 0 and the status byte reads 0x13.
- R11: Instruction bytes `00001xxx` are accepted as no-operations. They set busy but change no mode and pulse no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phi_i | input | 1 | Slow internal clock that times the busy window |
| ce_ni | input | 1 | Bus chip enable, active low |
| wr_ni | input | 1 | Bus write select, 0 = write, 1 = read |
| di_i | input | 1 | 1 = display data, 0 = instruction/status |
| db_i | input | 8 | Bus data in |
| db_o | output | 8 | Bus data out (status or output register) |
| db_oe_o | output | 1 | Bus output enable |
| busy_o | output | 1 | Busy window open |
| disp_on_o | output | 1 | Display enable |
| cnt_y_o | output | 1 | Counter select, 1 = page counter |
| cnt_up_o | output | 1 | Count direction, 1 = up |
| flag_mode_o | output | 1 | Flag memory selected |
| xload_o | output | 1 | Column address load strobe |
| xval_o | output | 6 | Column address value |
| pload_o | output | 1 | Page address load strobe |
| pval_o | output | 4 | Page address value |
| zload_o | output | 1 | Start line load strobe |
| zval_o | output | 6 | Start line value |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Byte at the current memory address |
| step_o | output | 1 | Address step strobe |

## Verification
A busy timer stuck high shows in the very next status read as bit 7 held. Every later transaction then disappears, so the address strobes and memory strobes stay silent. A busy timer that clears early lets a second transaction through, which shows up as a mode change or a strobe one cycle after its completing edge. A wrong output register shows on the second read after an address load, not the first. Mode register faults show in the status byte on the next status read and on the mode outputs one cycle after the instruction completes.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned COL_W  = 6;
  localparam int unsigned PAGE_W = 4;
  localparam int unsigned LINE_W = 6;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_INSTR = 2'd1,
    EV_WDATA = 2'd2,
    EV_RDATA = 2'd3
  } bus_ev_e;
endpackage

// File: rtl/bus_front.sv
module bus_front
  import lcd_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              wr_ni,
  input  logic              di_i,
  output bus_ev_e           ev_o
);
  logic ce_q;
  logic ce_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b1;
    else         ce_q <= ce_ni;
  end

  assign ce_rise = ce_ni & ~ce_q;

  // status read completes as EV_NONE
  always_comb begin
    ev_o = EV_NONE;
    if (ce_rise) begin
      unique case ({wr_ni, di_i})
        2'b00:   ev_o = EV_INSTR;
        2'b01:   ev_o = EV_WDATA;
        2'b11:   ev_o = EV_RDATA;
        default: ev_o = EV_NONE;
      endcase
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int unsigned EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(EDGES + 1);

  logic             phi_q;
  logic             phi_rise;
  logic [CNT_W-1:0] cnt_q;

  assign phi_rise = phi_i & ~phi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi_q  <= 1'b0;
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      phi_q <= phi_i;
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o && phi_rise) begin
        if (cnt_q == CNT_W'(EDGES - 1)) begin
          busy_o <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_busy_fall_on_phi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(phi_i && !phi_q));

  p_busy_after_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import lcd_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] op_i,
  output logic              disp_on_o,
  output logic              cnt_y_o,
  output logic              cnt_up_o,
  output logic              flag_mode_o,
  output logic              xload_o,
  output logic [COL_W-1:0]  xval_o,
  output logic              pload_o,
  output logic [PAGE_W-1:0] pval_o,
  output logic              zload_o,
  output logic [LINE_W-1:0] zval_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_on_o   <= 1'b0;
      cnt_y_o     <= 1'b1;
      cnt_up_o    <= 1'b1;
      flag_mode_o <= 1'b0;
      xload_o     <= 1'b0;
      pload_o     <= 1'b0;
      zload_o     <= 1'b0;
      xval_o      <= '0;
      pval_o      <= '0;
      zval_o      <= '0;
    end else begin
      xload_o <= 1'b0;
      pload_o <= 1'b0;
      zload_o <= 1'b0;
      if (vld_i) begin
        casez (op_i)
          8'b11??????: begin
            pload_o     <= 1'b1;
            pval_o      <= op_i[PAGE_W-1:0];
            flag_mode_o <= op_i[4];
          end
          8'b10??????: begin
            xload_o <= 1'b1;
            xval_o  <= op_i[COL_W-1:0];
          end
          8'b01??????: begin
            zload_o <= 1'b1;
            zval_o  <= op_i[LINE_W-1:0];
          end
          8'b000001??: begin
            cnt_y_o  <= op_i[1];
            cnt_up_o <= op_i[0];
          end
          8'b0000001?: disp_on_o <= op_i[0];
          default: ; // test mode and unused codes: no-op
        endcase
      end
    end
  end

  p_disp_only_by_op_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_on_o) |-> $past(vld_i));

  p_mode_only_by_op_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt_y_o) || !$stable(cnt_up_o)) |-> $past(vld_i));

  p_load_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xload_o, pload_o, zload_o}));
endmodule

// File: rtl/data_port.sv
module data_port
  import lcd_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] out_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o       <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_wdata_o <= '0;
      step_o      <= 1'b0;
    end else begin
      mem_rd_o <= rd_i;
      mem_wr_o <= wr_i;
      step_o   <= rd_i | wr_i;
      if (rd_i) out_o       <= mem_rdata_i;
      if (wr_i) mem_wdata_o <= wdata_i;
    end
  end

  p_out_refill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (out_o == $past(mem_rdata_i)));

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(out_o));
endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int unsigned BUSY_EDGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi_i,
  input  logic              ce_ni,
  input  logic              wr_ni,
  input  logic              di_i,
  input  logic [7:0]        db_i,
  output logic [7:0]        db_o,
  output logic              db_oe_o,
  output logic              busy_o,
  output logic              disp_on_o,
  output logic              cnt_y_o,
  output logic              cnt_up_o,
  output logic              flag_mode_o,
  output logic              xload_o,
  output logic [5:0]        xval_o,
  output logic              pload_o,
  output logic [3:0]        pval_o,
  output logic              zload_o,
  output logic [5:0]        zval_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              step_o
);
  bus_ev_e           ev;
  logic              acc;
  logic [BYTE_W-1:0] out_reg;
  logic [BYTE_W-1:0] status;

  bus_front u_front (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ce_ni),
    .wr_ni (wr_ni),
    .di_i  (di_i),
    .ev_o  (ev)
  );

  assign acc = (ev != EV_NONE) && !busy_o;

  busy_timer #(.EDGES(BUSY_EDGES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phi_i  (phi_i),
    .start_i(acc),
    .busy_o (busy_o)
  );

  cmd_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (acc && ev == EV_INSTR),
    .op_i       (db_i),
    .disp_on_o  (disp_on_o),
    .cnt_y_o    (cnt_y_o),
    .cnt_up_o   (cnt_up_o),
    .flag_mode_o(flag_mode_o),
    .xload_o    (xload_o),
    .xval_o     (xval_o),
    .pload_o    (pload_o),
    .pval_o     (pval_o),
    .zload_o    (zload_o),
    .zval_o     (zval_o)
  );

  data_port u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (acc && ev == EV_RDATA),
    .wr_i       (acc && ev == EV_WDATA),
    .wdata_i    (db_i),
    .mem_rdata_i(mem_rdata_i),
    .out_o      (out_reg),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o),
    .step_o     (step_o)
  );

  assign status  = {busy_o, 1'b0, disp_on_o, ~rst_ni, 1'b0, flag_mode_o, cnt_y_o, cnt_up_o};
  assign db_o    = di_i ? out_reg : status;
  assign db_oe_o = ~ce_ni & wr_ni;

  p_no_access_when_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || mem_rd_o || xload_o || pload_o || zload_o) |-> !$past(busy_o));

  p_strobe_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, xload_o, pload_o, zload_o}));

  p_step_with_access_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (mem_rd_o || mem_wr_o));

  p_access_needs_ce_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || mem_rd_o) |-> $past(ce_ni));
endmodule

// File: tb/sim_lcd_bus_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_bus_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phi = 1'b0;
  logic       ce_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       di = 1'b0;
  logic [7:0] db = 8'h00;
  logic [7:0] db_o;
  logic       db_oe, busy, disp_on, cnt_y, cnt_up, flag_mode;
  logic       xload, pload, zload, mem_rd, mem_wr, step;
  logic [5:0] xval, zval;
  logic [3:0] pval;
  logic [7:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lcd_bus_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .phi_i(phi), .ce_ni(ce_n), .wr_ni(wr_n), .di_i(di),
    .db_i(db), .db_o(db_o), .db_oe_o(db_oe), .busy_o(busy), .disp_on_o(disp_on),
    .cnt_y_o(cnt_y), .cnt_up_o(cnt_up), .flag_mode_o(flag_mode),
    .xload_o(xload), .xval_o(xval), .pload_o(pload), .pval_o(pval),
    .zload_o(zload), .zval_o(zval), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .step_o(step)
  );

  // slow clock: 16 system cycles per period
  int phi_cnt = 0;
  always @(negedge clk) begin
    phi_cnt = (phi_cnt + 1) % 8;
    if (phi_cnt == 0) phi = ~phi;
  end

  // external memory and column counter
  logic [7:0] mem [0:63];
  int         baddr = 0;
  assign mem_rdata = mem[baddr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
      baddr <= 0;
    end else begin
      if (mem_wr) mem[baddr] <= mem_wdata;
      if (xload)     baddr <= int'(xval);
      else if (step) baddr <= (baddr + 1) % 64;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int   m_ce_q, m_phi_q, m_busy, m_edges;
  int   m_disp, m_y, m_up, m_flag, m_out;
  int   m_wr, m_rd, m_step, m_xl, m_pl, m_zl, m_xv, m_pv, m_zv, m_wd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ce_q = 1; m_phi_q = 0; m_busy = 0; m_edges = 0;
      m_disp = 0; m_y = 1; m_up = 1; m_flag = 0; m_out = 0;
      m_wr = 0; m_rd = 0; m_step = 0; m_xl = 0; m_pl = 0; m_zl = 0;
      m_xv = 0; m_pv = 0; m_zv = 0; m_wd = 0;
    end else begin
      bit rise, prise, acc;
      int b;
      rise  = (ce_n == 1'b1) && (m_ce_q == 0);
      prise = (phi == 1'b1) && (m_phi_q == 0);
      acc   = rise && !(wr_n == 1'b1 && di == 1'b0) && (m_busy == 0);
      b     = int'(db);
      m_wr = 0; m_rd = 0; m_step = 0; m_xl = 0; m_pl = 0; m_zl = 0;
      if (m_busy != 0 && prise) begin
        m_edges++;
        if (m_edges == 2) begin m_busy = 0; m_edges = 0; end
      end
      if (acc) begin
        m_busy = 1; m_edges = 0;
        if (wr_n == 1'b0 && di == 1'b1) begin
          m_wr = 1; m_step = 1; m_wd = b;
        end else if (wr_n == 1'b1) begin
          m_rd = 1; m_step = 1; m_out = int'(mem_rdata);
        end else if (b >= 8'hC0) begin
          m_pl = 1; m_pv = b % 16; m_flag = (b / 16) % 2;
        end else if (b >= 8'h80) begin
          m_xl = 1; m_xv = b % 64;
        end else if (b >= 8'h40) begin
          m_zl = 1; m_zv = b % 64;
        end else if (b >= 8'h08) begin
          // test mode: nothing
        end else if (b >= 8'h04) begin
          m_y = (b / 2) % 2; m_up = b % 2;
        end else if (b >= 8'h02) begin
          m_disp = b % 2;
        end
      end
      m_ce_q  = int'(ce_n);
      m_phi_q = int'(phi);
    end
  end

  function automatic int m_status();
    return m_busy * 128 + m_disp * 32 + m_flag * 4 + m_y * 2 + m_up;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 busy", 32'(busy), 32'(m_busy));
      chk("R2 display", 32'(disp_on), 32'(m_disp));
      chk("R3 counter select", 32'(cnt_y), 32'(m_y));
      chk("R3 direction", 32'(cnt_up), 32'(m_up));
      chk("R4 flag mode", 32'(flag_mode), 32'(m_flag));
      chk("R4 strobes", {29'd0, xload, pload, zload}, 32'(m_xl * 4 + m_pl * 2 + m_zl));
      if (m_xl != 0) chk("R4 x value", 32'(xval), 32'(m_xv));
      if (m_pl != 0) chk("R4 page value", 32'(pval), 32'(m_pv));
      if (m_zl != 0) chk("R4 line value", 32'(zval), 32'(m_zv));
      chk("R9 write strobe", 32'(mem_wr), 32'(m_wr));
      if (m_wr != 0) chk("R9 write data", 32'(mem_wdata), 32'(m_wd));
      chk("R8 read strobe", 32'(mem_rd), 32'(m_rd));
      chk("R8 step", 32'(step), 32'(m_step));
      chk("R1 output enable", 32'(db_oe), 32'(!ce_n && wr_n));
      if (db_oe) chk(di ? "R8 read data" : "R5 status", 32'(db_o), di ? 32'(m_out) : 32'(m_status()));
    end
  end

  task automatic bus_wr(input logic d, input logic [7:0] b);
    @(negedge clk); di = d; wr_n = 1'b0; db = b; ce_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic d, output logic [7:0] v);
    @(negedge clk); di = d; wr_n = 1'b1; ce_n = 1'b0;
    @(negedge clk); v = db_o; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 200; k++) begin
      bus_rd(1'b0, s);
      if (!s[7]) return;
    end
    chk("R6 busy never clears", 32'd1, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    // R10: status while reset is held
    repeat (3) @(negedge clk);
    di = 1'b0; wr_n = 1'b1; ce_n = 1'b0;
    @(negedge clk);
    chk("R10 status in reset", 32'(db_o), 32'h13);
    chk("R10 outputs in reset", {28'd0, disp_on, cnt_y, cnt_up, flag_mode}, 32'b0110);
    ce_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_rd(1'b0, v); chk("R5 idle status", 32'(v), 32'h03);

    // R2 display on, then busy visible at once (R6)
    bus_wr(1'b0, 8'h03);
    bus_rd(1'b0, v); chk("R6 busy bit after instruction", 32'(v), 32'hA3);
    // R7: dropped while busy
    bus_wr(1'b0, 8'h04);
    wait_ready();
    chk("R7 dropped counter select", {30'd0, cnt_y, cnt_up}, 32'b11);
    chk("R2 display on", 32'(disp_on), 32'd1);

    bus_wr(1'b0, 8'h04); wait_ready();
    bus_rd(1'b0, v); chk("R3 column counter down", 32'(v), 32'h20);
    bus_wr(1'b0, 8'h07); wait_ready();

    // R11 test mode no-op
    bus_wr(1'b0, 8'h0D);
    bus_rd(1'b0, v); chk("R11 test mode busy, no change", 32'(v), 32'hA3);
    wait_ready();

    // R4 loads
    bus_wr(1'b0, 8'hF3); wait_ready();
    chk("R4 page value", 32'(pval), 32'd3);
    bus_rd(1'b0, v); chk("R4 flag in status", 32'(v), 32'h27);
    bus_wr(1'b0, 8'hC0); wait_ready();
    bus_wr(1'b0, 8'h6A); wait_ready();
    chk("R4 start line", 32'(zval), 32'h2A);
    bus_wr(1'b0, 8'h85); wait_ready();
    chk("R4 column address", 32'(xval), 32'd5);

    // R9 writes
    bus_wr(1'b1, 8'hA1); wait_ready();
    bus_wr(1'b1, 8'hB2); wait_ready();
    bus_wr(1'b1, 8'hC3);
    bus_wr(1'b1, 8'hEE);   // R7: lands while busy
    wait_ready();
    chk("R9 mem[5]", 32'(mem[5]), 32'hA1);
    chk("R9 mem[7]", 32'(mem[7]), 32'hC3);
    chk("R7 dropped write mem[8]", 32'(mem[8]), 32'h00);

    // R2: display off leaves memory alone
    bus_wr(1'b0, 8'h02); wait_ready();
    chk("R2 memory kept", 32'(mem[6]), 32'hB2);

    // R8 pipelined reads
    bus_wr(1'b0, 8'h85); wait_ready();
    bus_rd(1'b1, v); chk("R8 dummy read", 32'(v), 32'h00); wait_ready();
    bus_rd(1'b1, v); chk("R8 first real read", 32'(v), 32'hA1); wait_ready();
    bus_rd(1'b1, v); chk("R8 second real read", 32'(v), 32'hB2);
    bus_rd(1'b1, v); chk("R7 read while busy holds", 32'(v), 32'hC3);
    wait_ready();
    bus_rd(1'b1, v); chk("R8 read after drop", 32'(v), 32'hC3);
    wait_ready();

    summary();
    $finish;
  end
endmodule